// File: doc/BRIEF.md
# Deferred-Evaluation Processor Status Register

This block is the status register of a 16-bit processor core. It does not compute the six arithmetic flags on every ALU operation. Each update instead records what kind of operation ran, its result, its two operands, a rotate-index mask, a sign mask and a small bundle of flags that the ALU already had at hand. Carry, parity, aux carry, zero, sign and overflow are then derived from that record by combinational logic whenever they are read. The trap, interrupt-enable and direction flags are plain stored bits.

The record's operation kind is held as the state of a small machine. The states are EAGER, INC, DEC, SUB, SHL, SHR, SAR, ROL, ROR and PASS. An update strobe moves the machine to the state named by the operation tag, and tags above 8 go to EAGER. A load strobe moves it to PASS from any state, and PASS can be left only by a later update. With no strobe the machine holds its state. Reset enters EAGER with an all-zero flag bundle.

All flags are also packed into a 16-bit status word. A 16-bit word can be loaded back, for example after a flags pop. The ALU, the decoder and the stack are outside this block.

Top module: `flag_status_unit`

## Requirements
- R1: After reset the six arithmetic flags and the three control flags are 0, so the packed word reads 0xF02A.
- R2: In the packed word, carry is bit 0, parity bit 2, aux bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10 and overflow bit 11. Bits 1, 3, 5 and 12 to 15 always read 1.
- R3: An update with tag 0 (EAGER), or with any tag from 9 to 15, makes the six arithmetic flags equal the supplied bundle. The bundle bits are [0] carry, [1] parity, [2] aux, [3] zero, [4] sign and [5] overflow.
- R4: In tags 1 to 6, zero is result==0 and sign is (result AND sign mask)!=0. Parity is 1 when the 16-bit result has an even number of ones, and aux reads 0.
- R5: Tag 1 (INC) sets overflow when result equals the sign mask. Tag 2 (DEC) sets overflow when result equals the sign mask minus 1. Both take carry from bundle bit 0.
- R6: Tag 3 (SUB) takes overflow from the sign-mask bit of (src XOR dst) AND (dst XOR result), and takes carry from bundle bit 0.
- R7: Let k = src-1 modulo 2^16. Tag 4 (SHL) gives carry = (dst AND (sign mask >> k))!=0. Tag 5 (SHR) gives carry = dst bit k. Tag 6 (SAR) gives carry = dst bit k. When k is 16 or more, SHL and SHR give carry 0, and SAR gives bundle bit 4.
- R8: For tags 4, 5, 6, 7 and 8, overflow is set when dst and result differ in the sign-mask bit.
- R9: Let r = k AND the rotate mask. Tag 7 (ROL) gives carry = (dst AND (sign mask >> r))!=0. Tag 8 (ROR) gives carry = dst bit r, or 0 when r is 16 or more. Parity, aux, zero and sign come from the bundle.
- R10: A load sets trap, interrupt enable and direction from word bits 8, 9 and 10, and enters PASS. In PASS each arithmetic flag reads its own bit of the loaded word. A load has priority over an update and over the control-flag writes in the same cycle.
- R11: Each control flag changes only through its own write strobe or a load. Updates do not alter any control flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Record an ALU operation |
| upd_op | input | 4 | Operation tag (0 EAGER, 1 INC, 2 DEC, 3 SUB, 4 SHL, 5 SHR, 6 SAR, 7 ROL, 8 ROR) |
| upd_res | input | 16 | ALU result |
| upd_dst | input | 16 | Destination operand |
| upd_src | input | 16 | Source operand or shift count |
| upd_rmask | input | 16 | Rotate index mask |
| upd_smask | input | 16 | Sign mask, 0x0080 byte or 0x8000 word |
| upd_pre | input | 6 | Precomputed flag bundle |
| load_en | input | 1 | Load a packed status word |
| load_word | input | 16 | Word to load |
| tf_we | input | 1 | Trap flag write strobe |
| tf_wd | input | 1 | Trap flag write value |
| ie_we | input | 1 | Interrupt-enable write strobe |
| ie_wd | input | 1 | Interrupt-enable write value |
| df_we | input | 1 | Direction flag write strobe |
| df_wd | input | 1 | Direction flag write value |
| status_word | output | 16 | Packed status word |
| flag_c | output | 1 | Carry |
| flag_p | output | 1 | Parity |
| flag_a | output | 1 | Aux carry |
| flag_z | output | 1 | Zero |
| flag_s | output | 1 | Sign |
| flag_o | output | 1 | Overflow |
| flag_t | output | 1 | Trap |
| flag_i | output | 1 | Interrupt enable |
| flag_d | output | 1 | Direction |

## Verification
The assertions check the following on every cycle: the fixed reserved bits, the pass-through of a loaded word, the bundle flowing through after EAGER and rotate updates, the aux flag held at 0 in the lazy arithmetic states, the INC overflow rule, the SUB carry, and the control flags holding when nothing writes them. Only the bench's scenarios show the index-dependent shift and rotate carries. These cover out-of-range counts with the SAR sign fallback, rotate masks that push the index past the data width, the DEC and SUB overflow edges at both widths, and the priority of a load arriving in the same cycle as an update.

// File: rtl/flag_pkg.sv
package flag_pkg;

    typedef enum logic [3:0] {
        M_EAGER = 4'd0,
        M_INC   = 4'd1,
        M_DEC   = 4'd2,
        M_SUB   = 4'd3,
        M_SHL   = 4'd4,
        M_SHR   = 4'd5,
        M_SAR   = 4'd6,
        M_ROL   = 4'd7,
        M_ROR   = 4'd8,
        M_PASS  = 4'd9
    } mode_t;

    // bundle of flags the ALU already knows; cf is bit 0
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } pre_t;

    localparam int POS_C = 0;
    localparam int POS_P = 2;
    localparam int POS_A = 4;
    localparam int POS_Z = 6;
    localparam int POS_S = 7;
    localparam int POS_T = 8;
    localparam int POS_I = 9;
    localparam int POS_D = 10;
    localparam int POS_O = 11;
    localparam logic [15:0] FIXED_ONES = 16'hF02A;

    function automatic mode_t op_to_mode(input logic [3:0] op);
        mode_t m;
        case (op)
            4'd1:    m = M_INC;
            4'd2:    m = M_DEC;
            4'd3:    m = M_SUB;
            4'd4:    m = M_SHL;
            4'd5:    m = M_SHR;
            4'd6:    m = M_SAR;
            4'd7:    m = M_ROL;
            4'd8:    m = M_ROR;
            default: m = M_EAGER;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flag_shift_carry.sv
// Carry-out candidates for the shift and rotate states, from the recorded operands.
module flag_shift_carry #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] rmask,
    input  logic [DW-1:0] smask,
    input  logic          sar_fill,
    output logic          c_shl,
    output logic          c_shr,
    output logic          c_sar,
    output logic          c_rol,
    output logic          c_ror
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] LIM = DW'(DW);

    logic [DW-1:0] k;
    logic [DW-1:0] r;
    logic          k_ok;
    logic          r_ok;
    logic          dst_k;
    logic          dst_r;

    always_comb begin
        k     = cnt - ONE;
        r     = k & rmask;
        k_ok  = (k < LIM);
        r_ok  = (r < LIM);
        dst_k = k_ok ? dst[k[$clog2(DW)-1:0]] : 1'b0;
        dst_r = r_ok ? dst[r[$clog2(DW)-1:0]] : 1'b0;
        c_shl = k_ok && ((dst & (smask >> k)) != '0);
        c_shr = dst_k;
        c_sar = k_ok ? dst_k : sar_fill;
        c_rol = (dst & (smask >> r)) != '0;
        c_ror = dst_r;
    end

endmodule

// File: rtl/flag_result_eval.sv
// Result-derived flags and the overflow candidates of the lazy states.
module flag_result_eval #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] res,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] smask,
    output logic          zero,
    output logic          sign,
    output logic          even,
    output logic          ov_inc,
    output logic          ov_dec,
    output logic          ov_sub,
    output logic          ov_sh
);
    always_comb begin
        zero   = (res == '0);
        sign   = (res & smask) != '0;
        even   = ~(^res);
        ov_inc = (res == smask);
        ov_dec = (res == (smask - DW'(1)));
        ov_sub = (smask & (src ^ dst) & (dst ^ res)) != '0;
        ov_sh  = (smask & (dst ^ res)) != '0;
    end

endmodule

// File: rtl/flag_status_unit.sv
module flag_status_unit
    import flag_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [3:0]    upd_op,
    input  logic [DW-1:0] upd_res,
    input  logic [DW-1:0] upd_dst,
    input  logic [DW-1:0] upd_src,
    input  logic [DW-1:0] upd_rmask,
    input  logic [DW-1:0] upd_smask,
    input  logic [5:0]    upd_pre,
    input  logic          load_en,
    input  logic [15:0]   load_word,
    input  logic          tf_we,
    input  logic          tf_wd,
    input  logic          ie_we,
    input  logic          ie_wd,
    input  logic          df_we,
    input  logic          df_wd,
    output logic [15:0]   status_word,
    output logic          flag_c,
    output logic          flag_p,
    output logic          flag_a,
    output logic          flag_z,
    output logic          flag_s,
    output logic          flag_o,
    output logic          flag_t,
    output logic          flag_i,
    output logic          flag_d
);
    mode_t         mode_q;
    mode_t         mode_d;
    logic [DW-1:0] res_q;
    logic [DW-1:0] dst_q;
    logic [DW-1:0] src_q;
    logic [DW-1:0] rmask_q;
    logic [DW-1:0] smask_q;
    pre_t          pre_q;
    logic          tf_q;
    logic          ie_q;
    logic          df_q;

    logic c_shl, c_shr, c_sar, c_rol, c_ror;
    logic zero, sign, even, ov_inc, ov_dec, ov_sub, ov_sh;

    // next-state selection: load beats update, otherwise hold
    always_comb begin
        if (load_en) begin
            mode_d = M_PASS;
        end else if (upd_en) begin
            mode_d = op_to_mode(upd_op);
        end else begin
            mode_d = mode_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_EAGER;
        end else begin
            mode_q <= mode_d;
        end
    end

    // recorded operation and control flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            dst_q   <= '0;
            src_q   <= '0;
            rmask_q <= '0;
            smask_q <= '0;
            pre_q   <= '0;
            tf_q    <= 1'b0;
            ie_q    <= 1'b0;
            df_q    <= 1'b0;
        end else if (load_en) begin
            res_q   <= DW'(load_word);
            smask_q <= '0;
            tf_q    <= load_word[POS_T];
            ie_q    <= load_word[POS_I];
            df_q    <= load_word[POS_D];
        end else begin
            if (upd_en) begin
                res_q   <= upd_res;
                dst_q   <= upd_dst;
                src_q   <= upd_src;
                rmask_q <= upd_rmask;
                smask_q <= upd_smask;
                pre_q   <= pre_t'(upd_pre);
            end
            if (tf_we) tf_q <= tf_wd;
            if (ie_we) ie_q <= ie_wd;
            if (df_we) df_q <= df_wd;
        end
    end

    flag_shift_carry #(.DW(DW)) u_carry (
        .dst      (dst_q),
        .cnt      (src_q),
        .rmask    (rmask_q),
        .smask    (smask_q),
        .sar_fill (pre_q.sf),
        .c_shl    (c_shl),
        .c_shr    (c_shr),
        .c_sar    (c_sar),
        .c_rol    (c_rol),
        .c_ror    (c_ror)
    );

    flag_result_eval #(.DW(DW)) u_result (
        .res    (res_q),
        .dst    (dst_q),
        .src    (src_q),
        .smask  (smask_q),
        .zero   (zero),
        .sign   (sign),
        .even   (even),
        .ov_inc (ov_inc),
        .ov_dec (ov_dec),
        .ov_sub (ov_sub),
        .ov_sh  (ov_sh)
    );

    // output decode per state
    always_comb begin
        flag_c = 1'b0;
        flag_p = even;
        flag_a = 1'b0;
        flag_z = zero;
        flag_s = sign;
        flag_o = 1'b0;
        unique case (mode_q)
            M_EAGER: begin
                flag_c = pre_q.cf;
                flag_p = pre_q.pf;
                flag_a = pre_q.af;
                flag_z = pre_q.zf;
                flag_s = pre_q.sf;
                flag_o = pre_q.of;
            end
            M_INC: begin
                flag_c = pre_q.cf;
                flag_o = ov_inc;
            end
            M_DEC: begin
                flag_c = pre_q.cf;
                flag_o = ov_dec;
            end
            M_SUB: begin
                flag_c = pre_q.cf;
                flag_o = ov_sub;
            end
            M_SHL: begin
                flag_c = c_shl;
                flag_o = ov_sh;
            end
            M_SHR: begin
                flag_c = c_shr;
                flag_o = ov_sh;
            end
            M_SAR: begin
                flag_c = c_sar;
                flag_o = ov_sh;
            end
            M_ROL, M_ROR: begin
                flag_c = (mode_q == M_ROL) ? c_rol : c_ror;
                flag_p = pre_q.pf;
                flag_a = pre_q.af;
                flag_z = pre_q.zf;
                flag_s = pre_q.sf;
                flag_o = ov_sh;
            end
            M_PASS: begin
                flag_c = res_q[POS_C];
                flag_p = res_q[POS_P];
                flag_a = res_q[POS_A];
                flag_z = res_q[POS_Z];
                flag_s = res_q[POS_S];
                flag_o = res_q[POS_O];
            end
            default: ;
        endcase
    end

    assign flag_t = tf_q;
    assign flag_i = ie_q;
    assign flag_d = df_q;

    always_comb begin
        status_word        = FIXED_ONES;
        status_word[POS_C] = flag_c;
        status_word[POS_P] = flag_p;
        status_word[POS_A] = flag_a;
        status_word[POS_Z] = flag_z;
        status_word[POS_S] = flag_s;
        status_word[POS_T] = flag_t;
        status_word[POS_I] = flag_i;
        status_word[POS_D] = flag_d;
        status_word[POS_O] = flag_o;
    end

endmodule

// File: rtl/flag_status_checker.sv
module flag_status_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_en,
    input logic [3:0]    upd_op,
    input logic [DW-1:0] upd_res,
    input logic [DW-1:0] upd_smask,
    input logic [5:0]    upd_pre,
    input logic          load_en,
    input logic [15:0]   load_word,
    input logic          tf_we,
    input logic          ie_we,
    input logic          df_we,
    input logic [15:0]   status_word,
    input logic          flag_c,
    input logic          flag_p,
    input logic          flag_a,
    input logic          flag_z,
    input logic          flag_s,
    input logic          flag_o,
    input logic          flag_t,
    input logic          flag_i,
    input logic          flag_d
);
    logic upd_only;
    assign upd_only = rst_n && upd_en && !load_en;

    assert_fixed_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 16'hF02A) == 16'hF02A);

    assert_load_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load_en) |=>
            (flag_c == $past(load_word[0])) && (flag_p == $past(load_word[2])) &&
            (flag_a == $past(load_word[4])) && (flag_z == $past(load_word[6])) &&
            (flag_s == $past(load_word[7])) && (flag_o == $past(load_word[11])) &&
            (flag_t == $past(load_word[8])) && (flag_i == $past(load_word[9])) &&
            (flag_d == $past(load_word[10])));

    assert_eager_bundle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && (upd_op == 4'd0 || upd_op > 4'd8)) |=>
            ({flag_o, flag_s, flag_z, flag_a, flag_p, flag_c} == $past(upd_pre)));

    assert_lazy_aux_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && upd_op >= 4'd1 && upd_op <= 4'd6) |=> !flag_a);

    assert_inc_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && upd_op == 4'd1) |=>
            (flag_o == ($past(upd_res) == $past(upd_smask))) && (flag_c == $past(upd_pre[0])));

    assert_sub_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && upd_op == 4'd3) |=> (flag_c == $past(upd_pre[0])));

    assert_rot_bundle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && (upd_op == 4'd7 || upd_op == 4'd8)) |=>
            (flag_p == $past(upd_pre[1])) && (flag_a == $past(upd_pre[2])) &&
            (flag_z == $past(upd_pre[3])) && (flag_s == $past(upd_pre[4])));

    assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load_en && !tf_we && !ie_we && !df_we) |=>
            ($stable(flag_t) && $stable(flag_i) && $stable(flag_d)));

endmodule

bind flag_status_unit flag_status_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (upd_en),
    .upd_op      (upd_op),
    .upd_res     (upd_res),
    .upd_smask   (upd_smask),
    .upd_pre     (upd_pre),
    .load_en     (load_en),
    .load_word   (load_word),
    .tf_we       (tf_we),
    .ie_we       (ie_we),
    .df_we       (df_we),
    .status_word (status_word),
    .flag_c      (flag_c),
    .flag_p      (flag_p),
    .flag_a      (flag_a),
    .flag_z      (flag_z),
    .flag_s      (flag_s),
    .flag_o      (flag_o),
    .flag_t      (flag_t),
    .flag_i      (flag_i),
    .flag_d      (flag_d)
);

// File: tb/flag_status_unit_test.sv
`timescale 1ns/1ps
module flag_status_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_en = 1'b0;
    logic [3:0] upd_op = '0;
    logic [15:0] upd_res = '0, upd_dst = '0, upd_src = '0, upd_rmask = '0, upd_smask = '0;
    logic [5:0] upd_pre = '0;
    logic load_en = 1'b0;
    logic [15:0] load_word = '0;
    logic tf_we = 0, tf_wd = 0, ie_we = 0, ie_wd = 0, df_we = 0, df_wd = 0;
    logic [15:0] status_word;
    logic flag_c, flag_p, flag_a, flag_z, flag_s, flag_o, flag_t, flag_i, flag_d;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the recorded state
    int          m_op = 0;
    bit          m_pass = 0;
    logic [15:0] m_res = 0, m_dst = 0, m_src = 0, m_rm = 0, m_sm = 0;
    logic [5:0]  m_pre = 0;
    logic        m_t = 0, m_i = 0, m_d = 0;

    always #2 clk = ~clk;

    flag_status_unit uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_op(upd_op), .upd_res(upd_res),
        .upd_dst(upd_dst), .upd_src(upd_src), .upd_rmask(upd_rmask), .upd_smask(upd_smask),
        .upd_pre(upd_pre), .load_en(load_en), .load_word(load_word),
        .tf_we(tf_we), .tf_wd(tf_wd), .ie_we(ie_we), .ie_wd(ie_wd), .df_we(df_we), .df_wd(df_wd),
        .status_word(status_word), .flag_c(flag_c), .flag_p(flag_p), .flag_a(flag_a),
        .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .flag_t(flag_t), .flag_i(flag_i),
        .flag_d(flag_d)
    );

    function automatic logic [15:0] expect_word();
        logic c, p, a, z, s, o;
        int k, r, sp;
        c = m_pre[0]; p = m_pre[1]; a = m_pre[2]; z = m_pre[3]; s = m_pre[4]; o = m_pre[5];
        k = int'(16'(m_src - 16'd1));
        r = k & int'(m_rm);
        sp = m_sm[15] ? 15 : 7;
        if (m_pass) begin
            c = m_res[0]; p = m_res[2]; a = m_res[4]; z = m_res[6]; s = m_res[7]; o = m_res[11];
        end else if (m_op >= 1 && m_op <= 8) begin
            if (m_op <= 6) begin
                z = (m_res == 16'd0);
                s = (m_res & m_sm) != 0;
                p = ($countones(m_res) % 2) == 0;
                a = 1'b0;
            end
            o = (m_dst[sp] != m_res[sp]);
            case (m_op)
                1: o = (m_res == m_sm);
                2: o = (m_res == 16'(m_sm - 16'd1));
                3: o = (m_src[sp] != m_dst[sp]) && (m_dst[sp] != m_res[sp]);
                4: c = (k < 16) && (sp >= k) && m_dst[(sp >= k) ? sp - k : 0];
                5: c = (k < 16) && m_dst[(k < 16) ? k : 0];
                6: c = (k < 16) ? m_dst[(k < 16) ? k : 0] : m_pre[4];
                7: c = (sp >= r) && m_dst[(sp >= r) ? sp - r : 0];
                8: c = (r < 16) && m_dst[(r < 16) ? r : 0];
                default: ;
            endcase
        end
        return 16'hF02A | 16'(c) | (16'(p) << 2) | (16'(a) << 4) | (16'(z) << 6) |
               (16'(s) << 7) | (16'(m_t) << 8) | (16'(m_i) << 9) | (16'(m_d) << 10) |
               (16'(o) << 11);
    endfunction

    task automatic check(input string req);
        logic [15:0] e;
        logic [15:0] pins;
        e = expect_word();
        pins = 16'hF02A | 16'(flag_c) | (16'(flag_p) << 2) | (16'(flag_a) << 4) |
               (16'(flag_z) << 6) | (16'(flag_s) << 7) | (16'(flag_t) << 8) |
               (16'(flag_i) << 9) | (16'(flag_d) << 10) | (16'(flag_o) << 11);
        n_chk++;
        if (status_word !== e || pins !== e) begin
            n_bad++;
            $display("FAIL %s op=%0d word=%h pins=%h expected=%h", req, m_op, status_word, pins, e);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        upd_en = 0; load_en = 0; tf_we = 0; ie_we = 0; df_we = 0;
    endtask

    task automatic do_update(input int op, input logic [15:0] res, dst, src, rm, sm,
                             input logic [5:0] pre, input string req);
        upd_en = 1; upd_op = 4'(op); upd_res = res; upd_dst = dst; upd_src = src;
        upd_rmask = rm; upd_smask = sm; upd_pre = pre;
        step();
        m_op = op; m_pass = 0; m_res = res; m_dst = dst; m_src = src; m_rm = rm; m_sm = sm; m_pre = pre;
        check(req);
    endtask

    task automatic do_load(input logic [15:0] w, input bit with_upd, input string req);
        load_en = 1; load_word = w;
        if (with_upd) begin
            upd_en = 1; upd_op = 4'd1; upd_res = ~w; upd_smask = 16'h8000;
            tf_we = 1; tf_wd = ~w[8];
        end
        step();
        m_pass = 1; m_res = w; m_sm = 0; m_t = w[8]; m_i = w[9]; m_d = w[10];
        check(req);
    endtask

    task automatic do_ctl(input logic [2:0] we, input logic [2:0] wd, input string req);
        tf_we = we[0]; tf_wd = wd[0]; ie_we = we[1]; ie_wd = wd[1]; df_we = we[2]; df_wd = wd[2];
        step();
        if (we[0]) m_t = wd[0];
        if (we[1]) m_i = wd[1];
        if (we[2]) m_d = wd[2];
        check(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_0F1A;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1");
        // directed corners
        do_update(0, 16'h1234, 0, 0, 0, 16'h8000, 6'b101101, "R3");
        do_update(12, 16'h0, 0, 0, 0, 16'h0080, 6'b010010, "R3");
        do_update(1, 16'h0080, 16'h007F, 1, 0, 16'h0080, 6'b000001, "R5");
        do_update(2, 16'h7FFF, 16'h8000, 1, 0, 16'h8000, 6'b000000, "R5");
        do_update(2, 16'h0000, 16'h0001, 1, 0, 16'h8000, 6'b000000, "R4");
        do_update(3, 16'h7FFF, 16'h8000, 16'h0001, 0, 16'h8000, 6'b000001, "R6");
        do_update(4, 16'h0000, 16'h8000, 16'h0000, 0, 16'h8000, 6'b000000, "R7");
        do_update(4, 16'h0000, 16'h0080, 16'h0001, 0, 16'h0080, 6'b000000, "R7");
        do_update(5, 16'h0000, 16'h8000, 16'h0010, 0, 16'h8000, 6'b000000, "R7");
        do_update(6, 16'hFFFF, 16'h8000, 16'h0011, 0, 16'h8000, 6'b010000, "R7");
        do_update(6, 16'h0000, 16'h0001, 16'h0000, 0, 16'h8000, 6'b010000, "R8");
        do_update(7, 16'h0001, 16'h8000, 16'h0001, 16'h000F, 16'h8000, 6'b011110, "R9");
        do_update(8, 16'h0000, 16'h0001, 16'h0012, 16'h001F, 16'h8000, 6'b000000, "R9");
        do_load(16'h0FFF, 0, "R10");
        do_load(16'h0000, 0, "R2");
        do_load(16'h0D55, 1, "R10");
        do_ctl(3'b111, 3'b010, "R11");
        do_update(1, 16'h0001, 0, 0, 0, 16'h8000, 6'b0, "R11");
        // random mix
        for (int it = 0; it < 600; it++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 7) begin
                int op;
                logic [15:0] sm, rm;
                op = int'($urandom_range(0, 11));
                sm = $urandom_range(0, 1) ? 16'h8000 : 16'h0080;
                rm = ($urandom_range(0, 1)) ? 16'h000F : 16'h001F;
                do_update(op, 16'($urandom), 16'($urandom), 16'($urandom_range(0, 20)), rm, sm,
                          6'($urandom), (op == 0 || op > 8) ? "R3" :
                          (op <= 2) ? "R5" : (op == 3) ? "R6" : (op <= 6) ? "R7" : "R9");
            end else if (kind < 8) begin
                do_load(16'($urandom), $urandom_range(0, 1) == 1, "R10");
            end else begin
                do_ctl(3'($urandom), 3'($urandom), "R11");
            end
        end
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m_op = 0; m_pass = 0; m_pre = 0; m_res = 0; m_sm = 0; m_t = 0; m_i = 0; m_d = 0;
        check("R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule